// File: doc/BRIEF.md
# USB Host Interrupt Status Unit

This unit keeps the sticky interrupt status flags and the per-source interrupt enables of a USB 2.0 host controller, and drives the single interrupt request line. Other parts of the controller report raw happenings: a descriptor retiring, a short packet, a transaction error, a fatal system access error, async schedule advances, port change levels, the running frame index and the run/stop state. The unit qualifies these happenings, finds the edges it needs and turns them into status flags.

Software reads either register through a plain register port with one select bit. It clears status flags by writing ones to them and programs the enables by writing them directly. The request output is the registered OR of every enabled flag.

Top module: `usbh_irq_status`

## Requirements
- R1: After reset, the status register reads 0, the enable register reads 0 and `irq` is 0.
- R2: Status bit 0 sets when `td_retire` and `td_ioc` are high together, or when `short_pkt` is high. `td_retire` without `td_ioc` leaves the bit at 0.
- R3: Status bit 1 sets on `xact_err`, and status bit 4 sets on `sys_err`.
- R4: Status bit 2 sets when, on a port whose `port_handed` bit is 0, `port_change` or `port_resume` rises from 0 to 1. The same rises on a port whose `port_handed` bit is 1 have no effect.
- R5: Status bit 2 sets when `port_conn_chg` rises on a port whose `port_handed` bit is 1. The same rise on a port whose `port_handed` bit is 0 has no effect.
- R6: Status bit 3 sets when the wrap bit of `frame_index` falls from 1 to 0. The wrap bit is bit 13 when `list_size` is 0 (1024 entries), bit 12 when it is 1 (512 entries) and bit 11 when it is 2 or 3 (256 entries).
- R7: Status bit 5 sets on the first `async_advanced` that follows an `adv_doorbell` pulse in an earlier cycle. An advance with no doorbell pending has no effect, and each doorbell gives one set.
- R8: Writing status (`reg_sel`=0) clears each of bits 5:0 whose write data bit is 1. Bits written with 0 keep their value. A set event in the same cycle as a clear wins.
- R9: The enable register (`reg_sel`=1) holds bits 5:0 and reads 0 in bits 15:6. In the status register, bits 11:6 and 15:13 read 0.
- R10: `irq` equals the OR of status bits 5:0 ANDed with the enable bits, delayed by one register. It falls one cycle after the last enabled flag is cleared.
- R11: Status bit 12 (halted) reads 1 one cycle after `run_stop` is 0 while `exec_idle` is 1. Otherwise it reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| td_retire | input | 1 | A transfer descriptor retired this cycle |
| td_ioc | input | 1 | The retiring descriptor requests interrupt on completion |
| short_pkt | input | 1 | A short packet was received |
| xact_err | input | 1 | A transaction completed with an error |
| sys_err | input | 1 | A host system access failed |
| adv_doorbell | input | 1 | Software rang the async advance doorbell |
| async_advanced | input | 1 | The async schedule advanced |
| run_stop | input | 1 | Run/stop control level |
| exec_idle | input | 1 | Schedule execution has stopped |
| frame_index | input | 14 | Current frame index |
| list_size | input | 2 | Frame list size code |
| port_handed | input | NPORTS | Per port, 1 when ownership has been handed away |
| port_change | input | NPORTS | Per port, OR of its change bits |
| port_resume | input | NPORTS | Per port, force-resume level |
| port_conn_chg | input | NPORTS | Per port, connect-status-change level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is the frame list rollover, because the flag sets only at one wrap point that moves with the list size. The stimulus sweeps the full frame index range once for each size code and counts the flags it sees. The expected count follows from how often the selected bit falls. The ownership rules for port changes form the second hard case. Every ownership pattern of two ports is crossed with each kind of change level on each port, and the expected flag comes from the rule alone.

// File: rtl/usbh_irq_status.sv
module usbh_irq_status #(
  parameter int NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              td_retire,
  input  logic              td_ioc,
  input  logic              short_pkt,
  input  logic              xact_err,
  input  logic              sys_err,
  input  logic              adv_doorbell,
  input  logic              async_advanced,
  input  logic              run_stop,
  input  logic              exec_idle,
  input  logic [13:0]       frame_index,
  input  logic [1:0]        list_size,
  input  logic [NPORTS-1:0] port_handed,
  input  logic [NPORTS-1:0] port_change,
  input  logic [NPORTS-1:0] port_resume,
  input  logic [NPORTS-1:0] port_conn_chg,
  output logic              irq
);
  localparam int NSRC = 6;

  logic [NSRC-1:0]   sts, en, set_v, clr_v;
  logic              halted, door_pend, wrap_q;
  logic [NPORTS-1:0] chg_q, res_q, csc_q;

  wire wrap_bit = (list_size == 2'd0) ? frame_index[13] :
                  (list_size == 2'd1) ? frame_index[12] : frame_index[11];
  wire rollover = wrap_q & ~wrap_bit;

  wire [NPORTS-1:0] own_rise  = ((port_change & ~chg_q) | (port_resume & ~res_q)) & ~port_handed;
  wire [NPORTS-1:0] away_rise = port_conn_chg & ~csc_q & port_handed;
  wire port_hit = |(own_rise | away_rise);
  wire adv_hit  = door_pend & async_advanced;

  assign set_v = {adv_hit, sys_err, rollover, port_hit, xact_err, (td_retire & td_ioc) | short_pkt};
  assign clr_v = (reg_wr && !reg_sel) ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts       <= '0;
      en        <= '0;
      halted    <= 1'b0;
      door_pend <= 1'b0;
      wrap_q    <= 1'b0;
      chg_q     <= '0;
      res_q     <= '0;
      csc_q     <= '0;
      irq       <= 1'b0;
    end else begin
      sts       <= (sts & ~clr_v) | set_v;
      if (reg_wr && reg_sel) en <= reg_wdata[NSRC-1:0];
      halted    <= ~run_stop & exec_idle;
      door_pend <= adv_doorbell | (door_pend & ~async_advanced);
      wrap_q    <= wrap_bit;
      chg_q     <= port_change;
      res_q     <= port_resume;
      csc_q     <= port_conn_chg;
      irq       <= |(sts & en);
    end
  end

  assign reg_rdata = reg_sel ? {10'b0, en} : {3'b0, halted, 6'b0, sts};
endmodule

module usbh_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] sts,
  input logic [5:0] en,
  input logic       irq,
  input logic       halted,
  input logic       td_retire,
  input logic       td_ioc,
  input logic       short_pkt,
  input logic       xact_err,
  input logic       sys_err,
  input logic       run_stop,
  input logic       exec_idle,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [15:0] reg_wdata
);
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(sts & en)));
  p_ioc_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((td_retire && td_ioc) || short_pkt) |=> sts[0]);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !((td_retire && td_ioc) || short_pkt) |=> !$rose(sts[0]));
  p_err_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xact_err |=> sts[1]);
  p_syserr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |=> sts[4]);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[1] && !xact_err) |=> !sts[1]);
  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_stop && exec_idle) |=> halted);
endmodule

bind usbh_irq_status usbh_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sts(sts), .en(en), .irq(irq), .halted(halted),
  .td_retire(td_retire), .td_ioc(td_ioc), .short_pkt(short_pkt),
  .xact_err(xact_err), .sys_err(sys_err), .run_stop(run_stop),
  .exec_idle(exec_idle), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/sim_usbh_irq_status.sv
module sim_usbh_irq_status;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic td_retire = 0, td_ioc = 0, short_pkt = 0, xact_err = 0, sys_err = 0;
  logic adv_doorbell = 0, async_advanced = 0, run_stop = 1, exec_idle = 0;
  logic [13:0] frame_index = 0;
  logic [1:0] list_size = 0;
  logic [1:0] port_handed = 0, port_change = 0, port_resume = 0, port_conn_chg = 0;
  logic irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  usbh_irq_status #(.NPORTS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .td_retire(td_retire),
    .td_ioc(td_ioc), .short_pkt(short_pkt), .xact_err(xact_err), .sys_err(sys_err),
    .adv_doorbell(adv_doorbell), .async_advanced(async_advanced),
    .run_stop(run_stop), .exec_idle(exec_idle), .frame_index(frame_index),
    .list_size(list_size), .port_handed(port_handed), .port_change(port_change),
    .port_resume(port_resume), .port_conn_chg(port_conn_chg), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic wrreg(input logic sel, input logic [15:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    tick;
    reg_wr = 0; reg_sel = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    reg_sel = sel; #1 v = reg_rdata; reg_sel = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cnt;
    repeat (3) tick;
    rst_n = 1;
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 enable", v, 0);
    chk("R1 irq", {15'b0, irq}, 0);

    wrreg(1, 16'hFFFF); rd(1, v); chk("R9 enable width", v, 16'h003F);
    wrreg(1, 0);

    td_retire = 1; tick; td_retire = 0; rd(0, v); chk("R2 no ioc", v, 0);
    td_retire = 1; td_ioc = 1; tick; td_retire = 0; td_ioc = 0;
    rd(0, v); chk("R2 ioc", v, 16'h0001);
    wrreg(0, 16'h0001); rd(0, v); chk("R8 clear bit0", v, 0);
    short_pkt = 1; tick; short_pkt = 0; rd(0, v); chk("R2 short", v, 16'h0001);
    wrreg(0, 16'hFFFF); rd(0, v); chk("R9 reserved read", v, 0);

    xact_err = 1; tick; xact_err = 0; rd(0, v); chk("R3 xact", v, 16'h0002);
    sys_err = 1; tick; sys_err = 0; rd(0, v); chk("R3 sys", v, 16'h0012);
    wrreg(0, 16'h0000); rd(0, v); chk("R8 write zero", v, 16'h0012);
    wrreg(0, 16'h0010); rd(0, v); chk("R8 partial clear", v, 16'h0002);
    xact_err = 1; wrreg(0, 16'h0002); xact_err = 0;
    rd(0, v); chk("R8 set wins", v, 16'h0002);
    wrreg(0, 16'h003F);

    for (int o = 0; o < 4; o++)
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < 2; p++) begin
          port_handed = o[1:0]; tick;
          wrreg(0, 16'h003F);
          case (k)
            0: port_change[p] = 1;
            1: port_resume[p] = 1;
            default: port_conn_chg[p] = 1;
          endcase
          tick;
          rd(0, v);
          if (k == 2) chk("R5 handed connect change", v, o[p] ? 16'h0004 : 16'h0000);
          else        chk("R4 owned port change", v, o[p] ? 16'h0000 : 16'h0004);
          port_change = 0; port_resume = 0; port_conn_chg = 0;
          tick;
        end
    port_handed = 0;
    wrreg(0, 16'h003F);

    async_advanced = 1; tick; async_advanced = 0; rd(0, v); chk("R7 no doorbell", v, 0);
    adv_doorbell = 1; tick; adv_doorbell = 0; rd(0, v); chk("R7 doorbell only", v, 0);
    async_advanced = 1; tick; async_advanced = 0; rd(0, v); chk("R7 advance", v, 16'h0020);
    wrreg(0, 16'h0020);
    async_advanced = 1; tick; async_advanced = 0; rd(0, v); chk("R7 one per doorbell", v, 0);

    wrreg(1, 16'h0002);
    xact_err = 1; tick; xact_err = 0;
    chk("R10 irq lag", {15'b0, irq}, 0);
    tick; chk("R10 irq set", {15'b0, irq}, 1);
    wrreg(0, 16'h0002); chk("R10 irq hold", {15'b0, irq}, 1);
    tick; chk("R10 irq drop", {15'b0, irq}, 0);

    td_retire = 1; td_ioc = 1; xact_err = 1; sys_err = 1; adv_doorbell = 1;
    port_change = 2'b01; list_size = 2; frame_index = 14'h0800;
    tick;
    td_retire = 0; td_ioc = 0; xact_err = 0; sys_err = 0; adv_doorbell = 0;
    async_advanced = 1; frame_index = 0;
    tick;
    async_advanced = 0; port_change = 0; list_size = 0;
    rd(0, v); chk("R6 R7 all set", v, 16'h003F);
    wrreg(1, 0);
    for (int k = 0; k < 6; k++) begin
      wrreg(1, 16'(1 << k)); tick;
      chk("R10 per enable", {15'b0, irq}, 1);
    end
    wrreg(0, 16'h001F); tick; chk("R10 other bits ignored", {15'b0, irq}, 1);
    wrreg(0, 16'h0020); tick; chk("R10 all clear", {15'b0, irq}, 0);
    wrreg(1, 0);

    run_stop = 1; exec_idle = 1; tick; tick; rd(0, v); chk("R11 running", v, 0);
    run_stop = 0; exec_idle = 0; tick; tick; rd(0, v); chk("R11 stopping", v, 0);
    exec_idle = 1; tick; rd(0, v); chk("R11 halted", v, 16'h1000);
    wrreg(0, 16'hFFFF); rd(0, v); chk("R11 write ignored", v, 16'h1000);
    run_stop = 1; tick; rd(0, v); chk("R11 resume", v, 0);
    exec_idle = 0;

    for (int s = 0; s < 4; s++) begin
      list_size = 2'(s); frame_index = 0; tick;
      wrreg(0, 16'h003F);
      cnt = 0;
      for (int i = 1; i <= 16385; i++) begin
        frame_index = 14'(i);
        tick;
        rd(0, v);
        if (v[3]) begin cnt++; reg_wr = 1; reg_wdata = 16'h0008; end
        else begin reg_wr = 0; reg_wdata = 0; end
      end
      reg_wr = 0; reg_wdata = 0; tick;
      chk("R6 rollover count", 16'(cnt), (s == 0) ? 16'd1 : (s == 1) ? 16'd2 : 16'd4);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule